// File: doc/BRIEF.md
# Sleep-State Pin Override Controller

This block decides what every general-purpose pin presents to the pad ring while the chip sleeps and in the period right after it wakes. Each pin has a sleep-time output level and a sleep-time direction. Both are stored in registers of their own, separate from the run-time direction register. While the `sleep_i` input is high, the block replaces the run-time output value and output enable of every pin with the stored sleep values.

When sleep ends, two hold flags are raised. One keeps the pins frozen at their sleep state. The other keeps the input receivers switched off. Software releases each flag on its own by writing a one to its bit in a status word. Both flags are also raised by reset.

Software reaches the registers through a plain word-addressed read/write port with a 12-bit offset. Read data appears one cycle after the request. The default build covers 121 pins in four banks of 32.

Four pins (86 to 89) use a direction bit of opposite sense. Five pins (2, 5, 6, 7, 8) are not configurable.

Top module: `slp_pin_ctrl`

## Requirements
- R1: Word offsets are 0x000+b for the run direction of bank b, 0x010+b for the sleep level of bank b, 0x020+b for the sleep direction of bank b (b from 0 to 3), and 0x030 for status. Bit i of a bank word belongs to pin 32*b+i. A write takes effect at the next clock edge. A read request returns its data on `bus_rdata_o` one cycle later, and `bus_rdata_o` is zero in any cycle after which no read was requested.
- R2: A read of any other offset returns zero, and a write to it changes no register. Bits for pins 121 and above read zero and ignore writes.
- R3: Pins 2, 5, 6, 7 and 8 ignore writes in all three bank registers. Their bits read zero, and these pins are never driven (`pin_oe_o` low).
- R4: For pins 86 to 89 a direction bit of 1 means input and 0 means output, in both the run and the sleep direction registers. For every other pin, 1 means output.
- R5: After reset every sleep level bit is 0. Both direction registers hold "input" for every pin, so bits 22 to 25 of bank 2 read 1 and all other bits read 0. The status word reads 0x3.
- R6: With `sleep_i` low and the pin hold flag clear, `pin_oe_o` follows the run direction register and `pin_out_o` follows `run_out_i`.
- R7: While `sleep_i` is high, `pin_oe_o` follows the sleep direction register and `pin_out_o` follows the sleep level register, whatever `run_out_i` does.
- R8: At the clock edge that sees `sleep_i` fall, both hold flags are set. The pins keep their sleep values with no gap across the wake.
- R9: While the pin hold flag (status bit 1) is set, the pins keep their sleep values. Writing 1 to status bit 1 clears the flag and returns the pins to run mode.
- R10: While the receiver hold flag (status bit 0) is set, `rx_en_o` is low. Writing 1 to status bit 0 clears the flag and raises `rx_en_o`.
- R11: A clearing write to the status word in the same cycle as the fall of `sleep_i` loses: both flags end up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_i | input | 1 | High while the chip is in its low-power state |
| run_out_i | input | NUM_PINS | Run-time output level per pin from the GPIO datapath |
| bus_en_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Word offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the request |
| pin_out_o | output | NUM_PINS | Level presented to each pad |
| pin_oe_o | output | NUM_PINS | Output enable per pad, 1 = driven |
| rx_en_o | output | 1 | Input receiver enable |

## Verification
The wake event and a software release can land on the same clock edge. A set and a clear then compete for the same hold flag.

The bench provokes this by dropping `sleep_i` in the very cycle that carries a write of 0x3 to the status word. It then judges the result by reading the status word back, where 0x3 is expected, and by confirming that `rx_en_o` stays low and the pins still show their sleep values.

It also checks that the hand-over from sleep to hold leaves no cycle in which the pins fall back to run values.

// File: rtl/slp_pin_pkg.sv
package slp_pin_pkg;

    localparam int BANK_W    = 32;
    localparam int ADDR_W    = 12;
    localparam int INV_FIRST = 86;
    localparam int INV_LAST  = 89;

    localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h030;
    localparam int ST_RX_BIT  = 0;
    localparam int ST_PIN_BIT = 1;

    typedef enum logic [2:0] {
        GRP_RUN_DIR,
        GRP_SLP_LVL,
        GRP_SLP_DIR,
        GRP_STATUS,
        GRP_NONE
    } reg_grp_e;

    typedef struct packed {
        reg_grp_e   grp;
        logic [3:0] bank;
    } decode_t;

    typedef struct packed {
        logic pin_hold;
        logic rx_hold;
    } hold_t;

    function automatic logic pin_locked(int p);
        return (p == 2) || (p >= 5 && p <= 8);
    endfunction

    function automatic logic pin_inverted(int p);
        return (p >= INV_FIRST) && (p <= INV_LAST);
    endfunction

    function automatic logic [BANK_W-1:0] bank_writable(int b, int num_pins);
        logic [BANK_W-1:0] m;
        m = '0;
        for (int i = 0; i < BANK_W; i++) begin
            m[i] = ((b * BANK_W + i) < num_pins) && !pin_locked(b * BANK_W + i);
        end
        return m;
    endfunction

    function automatic logic [BANK_W-1:0] bank_inverted(int b, int num_pins);
        logic [BANK_W-1:0] m;
        m = '0;
        for (int i = 0; i < BANK_W; i++) begin
            m[i] = ((b * BANK_W + i) < num_pins) && pin_inverted(b * BANK_W + i);
        end
        return m;
    endfunction

    function automatic decode_t decode_addr(logic [ADDR_W-1:0] a, int num_banks);
        decode_t d;
        d.bank = a[3:0];
        d.grp  = GRP_NONE;
        if (a == OFS_STATUS) begin
            d.grp = GRP_STATUS;
        end else if (int'(a[3:0]) < num_banks) begin
            case (a[11:4])
                8'h00:   d.grp = GRP_RUN_DIR;
                8'h01:   d.grp = GRP_SLP_LVL;
                8'h02:   d.grp = GRP_SLP_DIR;
                default: d.grp = GRP_NONE;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/slp_pin_bank.sv
module slp_pin_bank
    import slp_pin_pkg::*;
#(
    parameter int BANK_IDX = 0,
    parameter int NUM_PINS = 121
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_run_dir,
    input  logic              wr_slp_lvl,
    input  logic              wr_slp_dir,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] run_dir_q,
    output logic [BANK_W-1:0] slp_lvl_q,
    output logic [BANK_W-1:0] slp_dir_q
);

    localparam logic [BANK_W-1:0] WR_MASK  = bank_writable(BANK_IDX, NUM_PINS);
    localparam logic [BANK_W-1:0] INV_MASK = bank_inverted(BANK_IDX, NUM_PINS);

    // Reset value of a direction word: every pin an input (inverted pins hold 1).
    localparam logic [BANK_W-1:0] DIR_RST  = INV_MASK;

    function automatic logic [BANK_W-1:0] merge(logic [BANK_W-1:0] old_v,
                                                logic [BANK_W-1:0] new_v);
        return (new_v & WR_MASK) | (old_v & ~WR_MASK);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            run_dir_q <= DIR_RST;
            slp_lvl_q <= '0;
            slp_dir_q <= DIR_RST;
        end else begin
            if (wr_run_dir) run_dir_q <= merge(run_dir_q, wdata);
            if (wr_slp_lvl) slp_lvl_q <= merge(slp_lvl_q, wdata);
            if (wr_slp_dir) slp_dir_q <= merge(slp_dir_q, wdata);
        end
    end

endmodule

// File: rtl/slp_hold_ctrl.sv
module slp_hold_ctrl
    import slp_pin_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sleep_i,
    input  logic  clr_rx,
    input  logic  clr_pin,
    output hold_t hold_q,
    output logic  sleep_q
);

    logic wake_edge;

    assign wake_edge = sleep_q && !sleep_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            sleep_q <= 1'b0;
        end else begin
            sleep_q <= sleep_i;
        end
    end

    // Set dominates clear: a wake edge wins over a release in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q.rx_hold  <= 1'b1;
            hold_q.pin_hold <= 1'b1;
        end else begin
            if (wake_edge)     hold_q.rx_hold <= 1'b1;
            else if (clr_rx)   hold_q.rx_hold <= 1'b0;

            if (wake_edge)     hold_q.pin_hold <= 1'b1;
            else if (clr_pin)  hold_q.pin_hold <= 1'b0;
        end
    end

endmodule

// File: rtl/slp_pin_mux.sv
module slp_pin_mux
    import slp_pin_pkg::*;
#(
    parameter int NUM_PINS = 121
) (
    input  logic                override,
    input  logic [NUM_PINS-1:0] run_dir,
    input  logic [NUM_PINS-1:0] slp_lvl,
    input  logic [NUM_PINS-1:0] slp_dir,
    input  logic [NUM_PINS-1:0] run_out,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam logic INV = pin_inverted(p);

        logic run_oe_w;
        logic slp_oe_w;

        assign run_oe_w   = run_dir[p] ^ INV;
        assign slp_oe_w   = slp_dir[p] ^ INV;
        assign pin_oe[p]  = override ? slp_oe_w   : run_oe_w;
        assign pin_out[p] = override ? slp_lvl[p] : run_out[p];
    end

endmodule

// File: rtl/slp_pin_ctrl.sv
module slp_pin_ctrl
    import slp_pin_pkg::*;
#(
    parameter int NUM_PINS = 121
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sleep_i,
    input  logic [NUM_PINS-1:0] run_out_i,
    input  logic                bus_en_i,
    input  logic                bus_we_i,
    input  logic [11:0]         bus_addr_i,
    input  logic [31:0]         bus_wdata_i,
    output logic [31:0]         bus_rdata_o,
    output logic [NUM_PINS-1:0] pin_out_o,
    output logic [NUM_PINS-1:0] pin_oe_o,
    output logic                rx_en_o
);

    localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;
    localparam int FLAT_W    = NUM_BANKS * BANK_W;

    decode_t dec;
    logic    wr_any;
    logic    rd_any;

    assign dec    = decode_addr(bus_addr_i, NUM_BANKS);
    assign wr_any = bus_en_i && bus_we_i;
    assign rd_any = bus_en_i && !bus_we_i;

    logic [BANK_W-1:0] run_dir_a [NUM_BANKS];
    logic [BANK_W-1:0] slp_lvl_a [NUM_BANKS];
    logic [BANK_W-1:0] slp_dir_a [NUM_BANKS];
    logic [FLAT_W-1:0] run_dir_flat;
    logic [FLAT_W-1:0] slp_lvl_flat;
    logic [FLAT_W-1:0] slp_dir_flat;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = wr_any && (dec.bank == b[3:0]);

        slp_pin_bank #(
            .BANK_IDX (b),
            .NUM_PINS (NUM_PINS)
        ) u_bank (
            .clk        (clk),
            .rst        (rst),
            .wr_run_dir (hit && dec.grp == GRP_RUN_DIR),
            .wr_slp_lvl (hit && dec.grp == GRP_SLP_LVL),
            .wr_slp_dir (hit && dec.grp == GRP_SLP_DIR),
            .wdata      (bus_wdata_i),
            .run_dir_q  (run_dir_a[b]),
            .slp_lvl_q  (slp_lvl_a[b]),
            .slp_dir_q  (slp_dir_a[b])
        );

        assign run_dir_flat[b*BANK_W +: BANK_W] = run_dir_a[b];
        assign slp_lvl_flat[b*BANK_W +: BANK_W] = slp_lvl_a[b];
        assign slp_dir_flat[b*BANK_W +: BANK_W] = slp_dir_a[b];
    end

    hold_t hold_q;
    logic  sleep_q;
    logic  st_wr;
    logic  rx_hold_w;
    logic  pin_hold_w;

    assign st_wr = wr_any && dec.grp == GRP_STATUS;

    slp_hold_ctrl u_hold (
        .clk     (clk),
        .rst     (rst),
        .sleep_i (sleep_i),
        .clr_rx  (st_wr && bus_wdata_i[ST_RX_BIT]),
        .clr_pin (st_wr && bus_wdata_i[ST_PIN_BIT]),
        .hold_q  (hold_q),
        .sleep_q (sleep_q)
    );

    assign rx_hold_w  = hold_q.rx_hold;
    assign pin_hold_w = hold_q.pin_hold;
    assign rx_en_o    = !rx_hold_w;

    // sleep_q covers the one cycle between the fall of sleep_i and the hold flag.
    logic override;
    assign override = sleep_i || sleep_q || pin_hold_w;

    slp_pin_mux #(
        .NUM_PINS (NUM_PINS)
    ) u_mux (
        .override (override),
        .run_dir  (run_dir_flat[NUM_PINS-1:0]),
        .slp_lvl  (slp_lvl_flat[NUM_PINS-1:0]),
        .slp_dir  (slp_dir_flat[NUM_PINS-1:0]),
        .run_out  (run_out_i),
        .pin_out  (pin_out_o),
        .pin_oe   (pin_oe_o)
    );

    logic [BANK_W-1:0] rd_val;
    logic [BANK_W-1:0] rdata_q;

    always_comb begin
        rd_val = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (dec.bank == 4'(b)) begin
                case (dec.grp)
                    GRP_RUN_DIR: rd_val = run_dir_a[b];
                    GRP_SLP_LVL: rd_val = slp_lvl_a[b];
                    GRP_SLP_DIR: rd_val = slp_dir_a[b];
                    default:     ;
                endcase
            end
        end
        if (dec.grp == GRP_STATUS) begin
            rd_val = '0;
            rd_val[ST_RX_BIT]  = rx_hold_w;
            rd_val[ST_PIN_BIT] = pin_hold_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rd_any ? rd_val : '0;
        end
    end

    assign bus_rdata_o = rdata_q;

endmodule

// File: rtl/slp_pin_ctrl_chk.sv
module slp_pin_ctrl_chk
    import slp_pin_pkg::*;
#(
    parameter int NUM_PINS = 121
) (
    input logic                clk,
    input logic                rst,
    input logic                sleep_i,
    input logic                bus_en_i,
    input logic                bus_we_i,
    input logic [11:0]         bus_addr_i,
    input logic [31:0]         bus_wdata_i,
    input logic [31:0]         bus_rdata_o,
    input logic [NUM_PINS-1:0] pin_out_o,
    input logic [NUM_PINS-1:0] pin_oe_o,
    input logic                rx_en_o,
    input logic                rx_hold,
    input logic                pin_hold
);

    localparam int NB = (NUM_PINS + BANK_W - 1) / BANK_W;

    function automatic logic [NUM_PINS-1:0] lock_mask();
        logic [NUM_PINS-1:0] m;
        for (int p = 0; p < NUM_PINS; p++) m[p] = pin_locked(p);
        return m;
    endfunction

    localparam logic [NUM_PINS-1:0] LOCK_MASK = lock_mask();

    function automatic logic unmapped(logic [11:0] a);
        if (a == 12'h030)      return 1'b0;
        if (a[11:6] != 6'd0)   return 1'b1;
        if (a[5:4] == 2'b11)   return 1'b1;
        return int'(a[3:0]) >= NB;
    endfunction

    logic slp_prev;
    always_ff @(posedge clk) begin
        if (rst) slp_prev <= 1'b0;
        else     slp_prev <= sleep_i;
    end

    logic wake;
    logic st_wr;
    assign wake  = slp_prev && !sleep_i;
    assign st_wr = bus_en_i && bus_we_i && bus_addr_i == 12'h030;

    // R8 and R11: a wake edge leaves both flags set, even with a clearing write.
    assert_wake_sets_holds_R8: assert property (@(posedge clk) disable iff (rst)
        wake |=> (rx_hold && pin_hold));

    // R9: pins frozen while holding and no register write happens.
    assert_hold_freezes_pins_R9: assert property (@(posedge clk) disable iff (rst)
        (pin_hold && !(bus_en_i && bus_we_i)) |=> ($stable(pin_out_o) && $stable(pin_oe_o)));

    // R9: a release write without a wake edge drops the pin hold.
    assert_pin_release_R9: assert property (@(posedge clk) disable iff (rst)
        (st_wr && bus_wdata_i[1] && !wake) |=> !pin_hold);

    // R3: locked pins are never driven.
    assert_locked_undriven_R3: assert property (@(posedge clk) disable iff (rst)
        (pin_oe_o & LOCK_MASK) == '0);

    // R2: reads of unmapped offsets return zero.
    assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_en_i && !bus_we_i && unmapped(bus_addr_i)) |=> (bus_rdata_o == 32'd0));

    // R10: receivers come back only after a release write to bit 0.
    assert_rx_release_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_en_o) |-> $past(st_wr && bus_wdata_i[0]));

endmodule

bind slp_pin_ctrl slp_pin_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sleep_i     (sleep_i),
    .bus_en_i    (bus_en_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .pin_out_o   (pin_out_o),
    .pin_oe_o    (pin_oe_o),
    .rx_en_o     (rx_en_o),
    .rx_hold     (rx_hold_w),
    .pin_hold    (pin_hold_w)
);

// File: tb/tb_slp_pin_ctrl.sv
module tb_slp_pin_ctrl;

    localparam int NP = 121;
    localparam int NB = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sleep_i = 1'b0;
    logic [NP-1:0] run_out_i = '0;
    logic          bus_en_i = 1'b0;
    logic          bus_we_i = 1'b0;
    logic [11:0]   bus_addr_i = '0;
    logic [31:0]   bus_wdata_i = '0;
    logic [31:0]   bus_rdata_o;
    logic [NP-1:0] pin_out_o;
    logic [NP-1:0] pin_oe_o;
    logic          rx_en_o;

    always #2 clk = ~clk;

    slp_pin_ctrl #(.NUM_PINS(NP)) dut (
        .clk(clk), .rst(rst), .sleep_i(sleep_i), .run_out_i(run_out_i),
        .bus_en_i(bus_en_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
        .pin_out_o(pin_out_o), .pin_oe_o(pin_oe_o), .rx_en_o(rx_en_o)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // Bench model of the three register groups, flat per pin.
    logic [127:0] m_run, m_lvl, m_dir;

    function automatic logic locked(int p);
        return p == 2 || (p >= 5 && p <= 8);
    endfunction

    function automatic logic inv(int p);
        return p >= 86 && p <= 89;
    endfunction

    function automatic logic [31:0] wmask(int b);
        logic [31:0] m;
        for (int i = 0; i < 32; i++) m[i] = (b*32+i) < NP && !locked(b*32+i);
        return m;
    endfunction

    function automatic logic [31:0] imask(int b);
        logic [31:0] m;
        for (int i = 0; i < 32; i++) m[i] = (b*32+i) < NP && inv(b*32+i);
        return m;
    endfunction

    function automatic logic [NP-1:0] oe_of(logic [127:0] d);
        logic [NP-1:0] v;
        for (int p = 0; p < NP; p++) v[p] = d[p] ^ inv(p);
        return v;
    endfunction

    task automatic chk32(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chkp(string tag, logic [NP-1:0] act, logic [NP-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_en_i = 1; bus_we_i = 1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_en_i = 0; bus_we_i = 0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en_i = 1; bus_we_i = 0; bus_addr_i = a;
        @(negedge clk);
        d = bus_rdata_o;
        bus_en_i = 0;
    endtask

    task automatic wr_model(int g, int b, logic [31:0] d);
        wr(12'(g*16 + b), d);
        case (g)
            0: m_run[b*32 +: 32] = d & wmask(b);
            1: m_lvl[b*32 +: 32] = d & wmask(b);
            default: m_dir[b*32 +: 32] = d & wmask(b);
        endcase
    endtask

    task automatic check_run(string tag);
        chkp({tag, " oe"},  pin_oe_o,  oe_of(m_run));
        chkp({tag, " out"}, pin_out_o, run_out_i);
    endtask

    task automatic check_slp(string tag);
        chkp({tag, " oe"},  pin_oe_o,  oe_of(m_dir));
        chkp({tag, " out"}, pin_out_o, m_lvl[NP-1:0]);
    endtask

    task automatic readback_all(string tag);
        logic [31:0] d;
        for (int b = 0; b < NB; b++) begin
            rd(12'(b), d);        chk32({tag, " run dir"}, d, m_run[b*32 +: 32]);
            rd(12'(16 + b), d);   chk32({tag, " slp lvl"}, d, m_lvl[b*32 +: 32]);
            rd(12'(32 + b), d);   chk32({tag, " slp dir"}, d, m_dir[b*32 +: 32]);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    logic [31:0] d;
    logic [31:0] pats [5];

    initial begin
        pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000; pats[2] = 32'hA5A5_A5A5;
        pats[3] = 32'h5A5A_5A5A; pats[4] = 32'h0F0F_33CC;
        m_run = '0; m_lvl = '0; m_dir = '0;
        for (int b = 0; b < NB; b++) begin
            m_run[b*32 +: 32] = imask(b);
            m_dir[b*32 +: 32] = imask(b);
        end
        repeat (3) @(negedge clk);
        rst = 0;

        // R5: reset state
        @(negedge clk);
        chk32("R5 rx_en after reset", {31'd0, rx_en_o}, 32'd0);
        chkp("R5 pins undriven after reset", pin_oe_o, '0);
        rd(12'h030, d); chk32("R5 status after reset", d, 32'h3);
        readback_all("R5 reset");

        // R10 / R9: release both flags
        wr(12'h030, 32'h3);
        @(negedge clk);
        chk32("R10 rx_en after release", {31'd0, rx_en_o}, 32'd1);
        rd(12'h030, d); chk32("R9 status after release", d, 32'h0);

        // R1 R2 R3: sweep of every group, bank and pattern
        for (int k = 0; k < 5; k++) begin
            for (int g = 0; g < 3; g++)
                for (int b = 0; b < NB; b++)
                    wr_model(g, b, pats[k] ^ (32'(g) << (4*b)));
            readback_all("R1 R2 R3 sweep");
        end

        // R2: unmapped offsets read zero and disturb nothing
        wr(12'h004, 32'hFFFF_FFFF); wr(12'h014, 32'hFFFF_FFFF);
        wr(12'h031, 32'hFFFF_FFFF); wr(12'h100, 32'hFFFF_FFFF);
        wr(12'hFFF, 32'hFFFF_FFFF);
        rd(12'h004, d); chk32("R2 unmapped 0x004", d, 0);
        rd(12'h031, d); chk32("R2 unmapped 0x031", d, 0);
        rd(12'hFFF, d); chk32("R2 unmapped 0xFFF", d, 0);
        rd(12'h03F, d); chk32("R2 unmapped 0x03F", d, 0);
        readback_all("R2 after unmapped writes");
        rd(12'h030, d); chk32("R2 status after unmapped writes", d, 32'h0);

        // R4: explicit inverted-pin check in run mode
        wr_model(0, 2, 32'h03E0_0000);  // bits 21..25 -> pins 85..89 set
        @(negedge clk);
        chk32("R4 pin85 output", {31'd0, pin_oe_o[85]}, 32'd1);
        chk32("R4 pins86-89 inputs", {28'd0, pin_oe_o[89:86]}, 32'd0);

        // R6 R7 R8 R9 R10: rounds with different patterns
        for (int k = 0; k < 4; k++) begin
            for (int b = 0; b < NB; b++) begin
                wr_model(0, b, pats[k] ^ 32'h1234_0000);
                wr_model(1, b, pats[(k+2)%5] ^ 32'(b*7));
                wr_model(2, b, pats[(k+1)%5] ^ 32'h00FF_0000);
            end
            run_out_i = {4{32'hC3C3_0000 ^ 32'(k)}};
            @(negedge clk);
            check_run("R6 run mode");
            run_out_i = ~run_out_i;
            @(negedge clk);
            check_run("R6 run mode new input");
            chkp("R3 locked pins never driven", pin_oe_o & {{(NP-9){1'b0}}, 9'b1_1110_0100}, '0);

            sleep_i = 1;
            @(negedge clk);
            check_slp("R7 sleep");
            run_out_i = ~run_out_i;
            @(negedge clk);
            check_slp("R7 sleep ignores run_out");

            sleep_i = 0;
            #1; check_slp("R8 no gap at wake");
            @(negedge clk);
            check_slp("R8 held after wake");
            chk32("R10 rx off after wake", {31'd0, rx_en_o}, 32'd0);
            rd(12'h030, d); chk32("R8 status after wake", d, 32'h3);

            wr(12'h030, 32'h2);
            @(negedge clk);
            check_run("R9 pins released");
            chk32("R10 rx still off", {31'd0, rx_en_o}, 32'd0);
            wr(12'h030, 32'h1);
            @(negedge clk);
            chk32("R10 rx released", {31'd0, rx_en_o}, 32'd1);
        end

        // R11: release write in the wake cycle loses
        sleep_i = 1;
        repeat (2) @(negedge clk);
        @(negedge clk);
        sleep_i = 0;
        bus_en_i = 1; bus_we_i = 1; bus_addr_i = 12'h030; bus_wdata_i = 32'h3;
        @(negedge clk);
        bus_en_i = 0; bus_we_i = 0;
        check_slp("R11 pins held after collision");
        chk32("R11 rx off after collision", {31'd0, rx_en_o}, 32'd0);
        rd(12'h030, d); chk32("R11 status after collision", d, 32'h3);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule